// File: doc/BRIEF.md
# Element-Width Saturating Integer Adder

This block adds or subtracts two 64-bit integer operands at an element width picked per operation by a 2-bit override code. The zero code keeps the full default width. The other three codes narrow the operation to 8, 16 or 32 bits. Only the low element-width bits of each operand are used. A signedness select makes those bits a two's-complement value or an unsigned magnitude.

With saturation disabled, the result wraps modulo 2^width. With saturation enabled, a result that falls outside the element's range is clamped to the nearest bound, and a flag reports that the clamp fired. The narrowed result is widened back to 64 bits: zero-extended for unsigned work and sign-extended for signed work.

The result, flag and valid strobe leave through one register stage, so they arrive one clock after the operation is presented. The result and flag keep their last values while no operation is presented.

Top module: `elw_sat_adder`

## Requirements
- R1: `width_code` selects the element width w: 2'b00 gives 64 (the default), 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32. Operand bits at position w and above have no effect on the result or the flag.
- R2: With `sub_sel`=0 the exact value is A+B. With `sub_sel`=1 it is A-B. A and B are the low w bits of `op_a` and `op_b`, read as unsigned when `signed_sel`=0 and as two's complement when `signed_sel`=1.
- R3: With `sat_en`=0, the low w bits of `result` equal the exact value modulo 2^w.
- R4: With `sat_en`=1 and `signed_sel`=0, an exact value above 2^w-1 gives 2^w-1. A value below 0 gives 0. Any other value passes through unchanged.
- R5: With `sat_en`=1 and `signed_sel`=1, an exact value above 2^(w-1)-1 gives 2^(w-1)-1. A value below -2^(w-1) gives -2^(w-1). Any other value passes through unchanged.
- R6: Result bits at position w and above copy bit w-1 of the result when `signed_sel`=1, and are zero when `signed_sel`=0. This applies to both wrapped and clamped results.
- R7: `sat_flag` is 1 exactly when `sat_en`=1 and the exact value lies outside the element range of R4 or R5. It is 0 whenever `sat_en`=0.
- R8: `valid_out` equals `valid_in` delayed by one rising clock edge. `result` and `sat_flag` belong to the operation presented at that edge.
- R9: When `valid_in` is 0 at a rising edge, `result` and `sat_flag` keep their previous values.
- R10: While `rst_n` is low, `valid_out`, `result` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | An operation is presented this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| width_code | input | 2 | Element width override code |
| sat_en | input | 1 | 1 clamps out-of-range results, 0 wraps them |
| signed_sel | input | 1 | 1 for signed operation, 0 for unsigned |
| sub_sel | input | 1 | 1 subtracts op_b from op_a, 0 adds |
| valid_out | output | 1 | Result is valid this cycle |
| result | output | 64 | Width-truncated and extended result |
| sat_flag | output | 1 | The clamp fired on this result |

## Verification
The bench sweeps every width, signedness, operation and saturation setting. It uses operand pairs at the range edges of each width: zero, one, both signed extremes and the unsigned maximum, with the upper operand bits deliberately polluted. It also runs a set of random pairs.

A design that compared against the wrong bound, such as the unsigned limit in signed mode, would clamp the wrong value or miss a clamp at the extremes. A design that let the polluted upper bits into the arithmetic would wrap or saturate wrongly at the narrow widths. A design that extended a clamped negative minimum with zeros would give a positive 64-bit value.

Idle cycles with changed operands are placed between operations to show that the registered result holds. The flag is checked in wrap mode to show it stays low even when the arithmetic overflows.

// File: rtl/elw_pkg.sv
// Package: shared constants and width decode for the element-width adder.
// Assumes the default (full) width is at least 32 bits.
package elw_pkg;
    localparam int NUM_CODES = 4;
    localparam int CODE_W    = $clog2(NUM_CODES);

    // Map a width-override code to an element width in bits.
    function automatic int lane_width(input int code, input int full_w);
        case (code)
            1:       return 8;
            2:       return 16;
            3:       return 32;
            default: return full_w;
        endcase
    endfunction
endpackage

// File: rtl/elw_lane.sv
// Module: one element-width arithmetic lane.
// Widens ELEM_W-bit operands into DATA_W+2 bits (signed or unsigned), adds
// or subtracts them exactly, then reports the wrapped result, the clamp
// value and whether the exact value overshoots the top or bottom bound.
// Assumes ELEM_W <= DATA_W.
module elw_lane #(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    input  logic              signed_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] wrap_o,
    output logic [DATA_W-1:0] clamp_o,
    output logic              above_o,
    output logic              below_o
);
    localparam int EXT_W = DATA_W + 2;
    localparam int PAD_W = EXT_W - ELEM_W;

    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] b_ext;
    logic signed [EXT_W-1:0] sum_ext;
    logic signed [EXT_W-1:0] max_ext;
    logic signed [EXT_W-1:0] min_ext;
    logic        [EXT_W-1:0] one_ext;

    assign one_ext = EXT_W'(1);

    // Widen operands per signedness and form the exact sum or difference.
    always_comb begin
        a_ext   = signed_i ? {{PAD_W{a_i[ELEM_W-1]}}, a_i} : {{PAD_W{1'b0}}, a_i};
        b_ext   = signed_i ? {{PAD_W{b_i[ELEM_W-1]}}, b_i} : {{PAD_W{1'b0}}, b_i};
        sum_ext = sub_i ? (a_ext - b_ext) : (a_ext + b_ext);
    end

    // Build the representable bounds of this element width.
    always_comb begin
        if (signed_i) begin
            max_ext = $signed((one_ext << (ELEM_W - 1)) - one_ext);
            min_ext = $signed(-(one_ext << (ELEM_W - 1)));
        end else begin
            max_ext = $signed((one_ext << ELEM_W) - one_ext);
            min_ext = '0;
        end
    end

    // Compare the exact value with the bounds and pick the clamp value.
    always_comb begin
        above_o = (sum_ext > max_ext);
        below_o = (sum_ext < min_ext);
        clamp_o = above_o ? max_ext[DATA_W-1:0] : min_ext[DATA_W-1:0];
    end

    // Truncate to the element and extend back to the full width.
    generate
        if (ELEM_W < DATA_W) begin : g_narrow
            localparam int FILL_W = DATA_W - ELEM_W;
            assign wrap_o = signed_i
                ? {{FILL_W{sum_ext[ELEM_W-1]}}, sum_ext[ELEM_W-1:0]}
                : {{FILL_W{1'b0}}, sum_ext[ELEM_W-1:0]};
        end else begin : g_full
            assign wrap_o = sum_ext[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/elw_select.sv
// Module: lane picker and saturation decision.
// Chooses the lane named by the width code, then gives either its clamp
// value (saturation on and out of range) or its wrapped value.
// Assumes lane k was built for the width that code k selects.
module elw_select #(
    parameter int DATA_W = 64,
    parameter int LANES  = elw_pkg::NUM_CODES,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES-1:0][DATA_W-1:0] wrap_i,
    input  logic [LANES-1:0][DATA_W-1:0] clamp_i,
    input  logic [LANES-1:0]             above_i,
    input  logic [LANES-1:0]             below_i,
    input  logic [SEL_W-1:0]             code_i,
    input  logic                         sat_en_i,
    output logic [DATA_W-1:0]            result_o,
    output logic                         sat_o
);
    logic out_of_range;

    // Pick the active lane and apply the wrap-or-clamp choice.
    always_comb begin
        out_of_range = above_i[code_i] | below_i[code_i];
        sat_o        = sat_en_i & out_of_range;
        result_o     = sat_o ? clamp_i[code_i] : wrap_i[code_i];
    end
endmodule

// File: rtl/elw_sat_adder.sv
// Module: element-width saturating integer adder (top).
// One lane per width code computes in parallel; the selector picks the
// coded lane; one register stage holds result and flag. The result and flag
// update only when valid_in is high. Reset is synchronous and active low.
module elw_sat_adder #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        width_code,
    input  logic              sat_en,
    input  logic              signed_sel,
    input  logic              sub_sel,
    output logic              valid_out,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int LANES = elw_pkg::NUM_CODES;

    logic [LANES-1:0][DATA_W-1:0] lane_wrap;
    logic [LANES-1:0][DATA_W-1:0] lane_clamp;
    logic [LANES-1:0]             lane_above;
    logic [LANES-1:0]             lane_below;
    logic [DATA_W-1:0]            next_result;
    logic                         next_sat;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            localparam int LW = elw_pkg::lane_width(k, DATA_W);
            elw_lane #(
                .DATA_W (DATA_W),
                .ELEM_W (LW)
            ) lane_i (
                .a_i      (op_a[LW-1:0]),
                .b_i      (op_b[LW-1:0]),
                .signed_i (signed_sel),
                .sub_i    (sub_sel),
                .wrap_o   (lane_wrap[k]),
                .clamp_o  (lane_clamp[k]),
                .above_o  (lane_above[k]),
                .below_o  (lane_below[k])
            );
        end
    endgenerate

    elw_select #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) select_i (
        .wrap_i   (lane_wrap),
        .clamp_i  (lane_clamp),
        .above_i  (lane_above),
        .below_i  (lane_below),
        .code_i   (width_code),
        .sat_en_i (sat_en),
        .result_o (next_result),
        .sat_o    (next_sat)
    );

    // Output stage: capture on valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result   <= next_result;
                sat_flag <= next_sat;
            end
        end
    end
endmodule

// File: rtl/elw_sat_adder_chk.sv
// Module: property checker for elw_sat_adder, attached by bind below.
module elw_sat_adder_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [1:0]        width_code,
    input logic              sat_en,
    input logic              signed_sel,
    input logic              valid_out,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    // R8: the strobe follows valid_in one edge later
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_out == $past(valid_in)));

    // R9: an idle edge leaves result and flag untouched
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_in)) |-> ($stable(result) && $stable(sat_flag)));

    // R7: no flag without saturation enabled
    a_r7_flag_needs_sat: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && !$past(sat_en)) |-> !sat_flag);

    // R6: unsigned byte results carry zero upper bits
    a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && !$past(signed_sel) && $past(width_code) == 2'b01)
        |-> (result[DATA_W-1:8] == '0));

    // R6: signed byte results repeat bit 7 upward
    a_r6_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && $past(signed_sel) && $past(width_code) == 2'b01)
        |-> (result[DATA_W-1:8] == {(DATA_W-8){result[7]}}));

    // R4: an unsigned byte clamp lands on 0 or 255
    a_r4_byte_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && !$past(signed_sel) && $past(width_code) == 2'b01 && sat_flag)
        |-> (result[7:0] == 8'h00 || result[7:0] == 8'hFF));

    // R5: a signed byte clamp lands on -128 or 127
    a_r5_byte_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && $past(signed_sel) && $past(width_code) == 2'b01 && sat_flag)
        |-> (result[7:0] == 8'h80 || result[7:0] == 8'h7F));

    // R10: outputs are clear in the cycle after a reset edge
    a_r10_reset_clear: assert property (@(posedge clk)
        (!$past(rst_n) && $past(rst_n, 2) !== 1'bx) |-> (!valid_out && !sat_flag && result == '0));
endmodule

bind elw_sat_adder elw_sat_adder_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .width_code (width_code),
    .sat_en     (sat_en),
    .signed_sel (signed_sel),
    .valid_out  (valid_out),
    .result     (result),
    .sat_flag   (sat_flag)
);

// File: tb/elw_sat_adder_tb_top.sv
// Bench: sweeps all width/sign/op/saturation settings over edge operands,
// then random pairs, with expected values from wide integer arithmetic.
module elw_sat_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  width_code = '0;
    logic        sat_en = 1'b0;
    logic        signed_sel = 1'b0;
    logic        sub_sel = 1'b0;
    logic        valid_out;
    logic [63:0] result;
    logic        sat_flag;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    always #10 clk = ~clk;

    elw_sat_adder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .op_a       (op_a),
        .op_b       (op_b),
        .width_code (width_code),
        .sat_en     (sat_en),
        .signed_sel (signed_sel),
        .sub_sel    (sub_sel),
        .valid_out  (valid_out),
        .result     (result),
        .sat_flag   (sat_flag)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h (code=%0d sat=%0b sgn=%0b sub=%0b a=%h b=%h)",
                     tag, act, exp, width_code, sat_en, signed_sel, sub_sel, op_a, op_b);
        end
    endtask

    function automatic int width_of(input logic [1:0] code);
        case (code)
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 32;
            default: return 64;
        endcase
    endfunction

    // Reference: exact arithmetic in 128 bits, then clamp or wrap.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] code,
                         input logic sat, input logic sgn, input logic sub,
                         output logic [63:0] res, output logic flg);
        int w;
        int sh;
        logic [127:0]        ua;
        logic [127:0]        ub;
        logic signed [127:0] ea;
        logic signed [127:0] eb;
        logic signed [127:0] ex;
        logic signed [127:0] hi;
        logic signed [127:0] lo;
        logic signed [127:0] wr;
        w  = width_of(code);
        sh = 128 - w;
        ua = {64'd0, a} << sh;
        ub = {64'd0, b} << sh;
        ea = sgn ? ($signed(ua) >>> sh) : $signed(ua >> sh);
        eb = sgn ? ($signed(ub) >>> sh) : $signed(ub >> sh);
        ex = sub ? (ea - eb) : (ea + eb);
        hi = sgn ? ((128'sd1 <<< (w - 1)) - 128'sd1) : ((128'sd1 <<< w) - 128'sd1);
        lo = sgn ? -(128'sd1 <<< (w - 1)) : 128'sd0;
        flg = sat && (ex > hi || ex < lo);
        if (flg) begin
            wr = (ex > hi) ? hi : lo;
        end else begin
            ua = ex << sh;
            wr = sgn ? ($signed(ua) >>> sh) : $signed(ua >> sh);
        end
        res = wr[63:0];
    endtask

    function automatic logic [63:0] edge_pat(input int idx, input int w, input logic [63:0] rnd);
        logic [63:0] one;
        logic [63:0] v;
        one = 64'd1;
        case (idx)
            0: v = 64'd0;
            1: v = one;
            2: v = (one << (w - 1)) - one;
            3: v = one << (w - 1);
            4: v = (one << w) - one;
            5: v = (one << w) - 64'd2;
            6: v = (one << (w - 1)) + one;
            default: v = rnd;
        endcase
        // pollute bits above the element (R1)
        if (w < 64) v = (v & ((one << w) - one)) | (64'hA5C3_96F0_5A3C_690F << w);
        return v;
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] code,
                          input logic sat, input logic sgn, input logic sub);
        logic [63:0] er;
        logic        ef;
        op_a = a; op_b = b; width_code = code;
        sat_en = sat; signed_sel = sgn; sub_sel = sub; valid_in = 1'b1;
        model(a, b, code, sat, sgn, sub, er, ef);
        @(negedge clk);
        check64("R8 valid_out", {63'd0, valid_out}, 64'd1);
        if (sat) check64(sgn ? "R5 R6 R1 R2 result" : "R4 R6 R1 R2 result", result, er);
        else     check64("R3 R6 R1 R2 result", result, er);
        check64("R7 sat_flag", {63'd0, sat_flag}, {63'd0, ef});
    endtask

    task automatic idle_check();
        logic [63:0] keep_r;
        logic        keep_f;
        keep_r = result;
        keep_f = sat_flag;
        valid_in = 1'b0;
        op_a = ~op_a; op_b = ~op_b; sat_en = ~sat_en; sub_sel = ~sub_sel;
        @(negedge clk);
        check64("R9 hold result", result, keep_r);
        check64("R9 hold flag", {63'd0, sat_flag}, {63'd0, keep_f});
        check64("R8 valid_out idle", {63'd0, valid_out}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R8 watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check64("R10 reset valid_out", {63'd0, valid_out}, 64'd0);
        check64("R10 reset result", result, 64'd0);
        check64("R10 reset flag", {63'd0, sat_flag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Edge sweep over every configuration
        for (int c = 0; c < 4; c++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        int w;
                        w = width_of(2'(c));
                        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
                        run_op(edge_pat(i, w, lfsr), edge_pat(j, w, ~lfsr), 2'(c),
                               cfg[2], cfg[1], cfg[0]);
                    end
                end
                idle_check();
            end
        end

        // Random pairs
        for (int k = 0; k < 800; k++) begin
            logic [63:0] ra;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            ra = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            run_op(ra, lfsr, ra[1:0], ra[2], ra[3], ra[4]);
            if (k % 50 == 0) idle_check();
        end

        // R10: reset after activity clears the outputs
        valid_in = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check64("R10 re-reset result", result, 64'd0);
        check64("R10 re-reset flag", {63'd0, sat_flag}, 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule